// File: doc/BRIEF.md
# Set-Associative Instruction Fetch Cache

This block is a read-only instruction cache. It sits between an instruction fetch port and a memory port that returns one 32-bit word per transfer. A fetch presents a byte address on a valid/ready channel, and only one fetch is in flight at a time. On a tag hit the addressed word comes back after a fixed hit latency. On a miss, a victim way is chosen from small per-way usage counters. The line is then refilled word by word, starting at the requested word and wrapping inside the aligned line, and the requested word is returned after a fixed miss latency.

The same request channel carries an invalidate-by-address command, selected by a flag. A global enable input and a per-fetch no-cache flag route a fetch straight to memory without touching cache state. A memory error during a refill discards the partly filled line. Any memory error returns a zero word together with a bus-error flag.

Top module: `ifetch_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0. Every way is invalid, so the first cached fetch to any address performs a refill.
- R2: For `LINE_BYTES=16` and `SETS=4`, the word in the line is `addr[3:2]`, the set is `addr[5:4]` and the tag is `addr[31:6]`. Bits [1:0] are ignored. A tag of all ones is stored and matched like any other tag, and it never hits before its own refill.
- R3: A cached fetch whose tag matches a way of its set returns that way's word with no memory read. `rsp_valid` rises exactly `HIT_DELAY+2` rising edges after the edge that accepted the request.
- R4: A miss issues exactly `LINE_BYTES/4` memory reads. The first read is at the requested word and each next read is the following word, wrapping modulo the line. Every `mem_addr` is word aligned and inside the aligned line, and it holds still while `mem_req` waits for `mem_ack`.
- R5: After a refill with no error, the response carries the requested word and the line holds its new tag, so later fetches to any word of that line hit.
- R6: Each way has a counter from 0 to `USTATES-1`, and all counters are 0 after reset. On a miss, the victim is the lowest-numbered way whose counter is below `USTATES-1` and smallest; if there is none, way 0 is the victim. After a refill, every nonzero counter in the set drops by one and the victim's counter becomes `USTATES-1`. On a hit, the counters above the hit way's counter drop by one and the hit way's counter becomes `USTATES-1`. If several ways match, the highest-numbered one is the hit.
- R7: With `cache_en` low or `req_nocache` high, a fetch makes exactly one read at the word-aligned address and returns that word. It changes no tag, counter or line.
- R8: If `mem_err` comes with a refill word, the refill stops at that word. The victim way is made invalid and its counter is set to 0, and the response is data 0 with `rsp_buserr` 1.
- R9: An invalidate (`req_inv`=1) with `cache_en` high clears the highest-numbered way whose tag matches, setting its counter to 0. If no way matches, nothing changes.
- R10: An invalidate with `cache_en` low clears every way of the indexed set and sets their counters to 0. Other sets keep their contents.
- R11: `req_ready` is high only when the block is idle. `rsp_valid` is a one-cycle pulse. An invalidate is taken in one cycle and gives no response.
- R12: A memory error on a bypass fetch returns data 0 with `rsp_buserr` 1 and leaves the cache state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cache_en | input | 1 | Global cache enable, sampled when a request is accepted |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is accepted when both valid and ready are high |
| req_addr | input | AW | Byte address of the fetch or invalidate |
| req_nocache | input | 1 | Fetch bypasses the cache |
| req_inv | input | 1 | Request is an invalidate, not a fetch |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Fetched word |
| rsp_buserr | output | 1 | Response carries a memory error |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | AW | Word-aligned memory read address |
| mem_ack | input | 1 | Memory read done this cycle |
| mem_rdata | input | 32 | Memory read data |
| mem_err | input | 1 | Memory read failed, valid with mem_ack |

## Verification
The bench builds the block with four sets, four ways, 16-byte lines, four counter states, a hit delay of 1 and a miss delay of 2. Four ways with four counter states make the counters take distinct, non-saturated values, so victim choice depends on the whole hit history and not only on the order in which ways were filled. Four words per line let the wrap of a refill start at every word position. The bench draws addresses from six tags over four sets, so hits, evictions and invalidates of the same lines recur often, and it injects memory errors at random points of refills and bypass fetches.

// File: rtl/ifetch_cache.sv
module ifetch_cache #(
  parameter int AW         = 32,
  parameter int SETS       = 4,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 16,
  parameter int USTATES    = 4,
  parameter int HIT_DELAY  = 1,
  parameter int MISS_DELAY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cache_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_nocache,
  input  logic          req_inv,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic          rsp_buserr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_err
);

  localparam int OFF   = $clog2(LINE_BYTES);
  localparam int WORDS = LINE_BYTES / 4;
  localparam int WB    = OFF - 2;
  localparam int IB    = $clog2(SETS);
  localparam int WW    = $clog2(WAYS);
  localparam int TW    = AW - OFF - IB;
  localparam int CW    = $clog2(USTATES);
  localparam logic [TW:0]   TAG_NONE = '1;
  localparam logic [CW-1:0] AGE_TOP  = CW'(USTATES - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_FILL, S_BYP, S_WAIT, S_RESP} st_t;

  st_t             st_q;
  logic [AW-1:2]   a_q;
  logic [WW-1:0]   vic_q;
  logic [WB-1:0]   fidx_q, fcnt_q;
  logic [15:0]     dly_q;
  logic [31:0]     data_q;
  logic            err_q;

  logic [TW:0]     tag_q  [SETS][WAYS];
  logic [CW-1:0]   age_q  [SETS][WAYS];
  logic [31:0]     line_q [SETS][WAYS][WORDS];

  wire [IB-1:0] set_a = a_q[OFF +: IB];
  wire [TW-1:0] tag_a = a_q[AW-1 -: TW];
  wire [WB-1:0] wrd_a = a_q[2 +: WB];
  wire [IB-1:0] set_i = req_addr[OFF +: IB];
  wire [TW-1:0] tag_i = req_addr[AW-1 -: TW];
  wire unused_low = &{1'b0, req_addr[1:0]};

  logic          hit, imatch;
  logic [WW-1:0] hway, iway, vway;
  logic [CW-1:0] vmin;

  always_comb begin
    hit = 1'b0;
    hway = '0;
    for (int w = 0; w < WAYS; w++)
      if (tag_q[set_a][w] == {1'b0, tag_a}) begin
        hit = 1'b1;
        hway = WW'(w);
      end
  end

  always_comb begin
    imatch = 1'b0;
    iway = '0;
    for (int w = 0; w < WAYS; w++)
      if (tag_q[set_i][w] == {1'b0, tag_i}) begin
        imatch = 1'b1;
        iway = WW'(w);
      end
  end

  always_comb begin
    vway = '0;
    vmin = AGE_TOP;
    for (int w = 0; w < WAYS; w++)
      if (age_q[set_a][w] < vmin) begin
        vway = WW'(w);
        vmin = age_q[set_a][w];
      end
  end

  assign req_ready  = (st_q == S_IDLE);
  assign rsp_valid  = (st_q == S_RESP);
  assign rsp_data   = data_q;
  assign rsp_buserr = rsp_valid & err_q;
  assign mem_req    = (st_q == S_FILL) || (st_q == S_BYP);
  assign mem_addr   = (st_q == S_FILL) ? {a_q[AW-1:OFF], fidx_q, 2'b00} : {a_q, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      a_q    <= '0;
      vic_q  <= '0;
      fidx_q <= '0;
      fcnt_q <= '0;
      dly_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= TAG_NONE;
          age_q[s][w] <= '0;
        end
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          if (req_inv) begin
            if (cache_en) begin
              if (imatch) begin
                tag_q[set_i][iway] <= TAG_NONE;
                age_q[set_i][iway] <= '0;
              end
            end else begin
              for (int w = 0; w < WAYS; w++) begin
                tag_q[set_i][w] <= TAG_NONE;
                age_q[set_i][w] <= '0;
              end
            end
          end else begin
            a_q  <= req_addr[AW-1:2];
            st_q <= (!cache_en || req_nocache) ? S_BYP : S_LOOK;
          end
        end
        S_LOOK: begin
          if (hit) begin
            data_q <= line_q[set_a][hway][wrd_a];
            err_q  <= 1'b0;
            for (int w = 0; w < WAYS; w++)
              if (age_q[set_a][w] > age_q[set_a][hway])
                age_q[set_a][w] <= age_q[set_a][w] - 1'b1;
            age_q[set_a][hway] <= AGE_TOP;
            dly_q <= 16'(HIT_DELAY);
            st_q  <= S_WAIT;
          end else begin
            vic_q  <= vway;
            fidx_q <= wrd_a;
            fcnt_q <= '0;
            st_q   <= S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          if (mem_err) begin
            tag_q[set_a][vic_q] <= TAG_NONE;
            age_q[set_a][vic_q] <= '0;
            data_q <= '0;
            err_q  <= 1'b1;
            dly_q  <= 16'(MISS_DELAY);
            st_q   <= S_WAIT;
          end else begin
            if (fcnt_q == '0) data_q <= mem_rdata;
            fidx_q <= fidx_q + 1'b1;
            fcnt_q <= fcnt_q + 1'b1;
            if (fcnt_q == WB'(WORDS - 1)) begin
              tag_q[set_a][vic_q] <= {1'b0, tag_a};
              for (int w = 0; w < WAYS; w++)
                if (age_q[set_a][w] != '0)
                  age_q[set_a][w] <= age_q[set_a][w] - 1'b1;
              age_q[set_a][vic_q] <= AGE_TOP;
              err_q <= 1'b0;
              dly_q <= 16'(MISS_DELAY);
              st_q  <= S_WAIT;
            end
          end
        end
        S_BYP: if (mem_ack) begin
          data_q <= mem_err ? 32'd0 : mem_rdata;
          err_q  <= mem_err;
          st_q   <= S_RESP;
        end
        S_WAIT: begin
          if (dly_q == '0) st_q <= S_RESP;
          else dly_q <= dly_q - 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (st_q == S_FILL && mem_ack && !mem_err)
      line_q[set_a][vic_q][fidx_q] <= mem_rdata;

endmodule

module ifetch_cache_chk #(
  parameter int AW  = 32,
  parameter int OFF = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_buserr,
  input logic [31:0]   rsp_data,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !rsp_valid);

  assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  assert_same_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> mem_addr[AW-1:OFF] == $past(mem_addr[AW-1:OFF]));

  assert_zero_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_buserr |-> rsp_valid && rsp_data == 32'd0);

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_busy_on_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

endmodule

bind ifetch_cache ifetch_cache_chk #(.AW(AW), .OFF(OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_buserr(rsp_buserr), .rsp_data(rsp_data), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/ifetch_cache_bench.sv
`timescale 1ns/1ps
module ifetch_cache_bench;
  localparam int AW = 32, SETS = 4, WAYS = 4, LB = 16, US = 4, HD = 1, MD = 2;
  localparam int WORDS = LB / 4;

  logic clk = 0, rst_n = 0, cache_en = 1;
  logic req_valid = 0, req_nocache = 0, req_inv = 0;
  logic [AW-1:0] req_addr = 0;
  logic req_ready, rsp_valid, rsp_buserr, mem_req;
  logic [31:0] rsp_data, mem_rdata = 0;
  logic [AW-1:0] mem_addr;
  logic mem_ack = 0, mem_err = 0;

  int checks = 0, errors = 0;
  int mtag [SETS][WAYS];
  int mlru [SETS][WAYS];
  logic [31:0] log_a [16];
  int log_n = 0;
  logic err_on = 0;
  logic [31:0] err_addr = 0;
  logic [31:0] exp_a [16];

  always #10 clk = ~clk;

  ifetch_cache #(.AW(AW), .SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LB), .USTATES(US),
                 .HIT_DELAY(HD), .MISS_DELAY(MD)) u_ifetch_cache (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_nocache(req_nocache),
    .req_inv(req_inv), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_buserr(rsp_buserr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err));

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E3779B1) + 32'h01234567;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : responder
    int wait_c = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 0; mem_err = 0;
      end else if (mem_req) begin
        if (wait_c > 0) wait_c--;
        else begin
          mem_ack = 1;
          mem_err = err_on && (mem_addr == err_addr);
          mem_rdata = mem_err ? 32'hDEADBEEF : memf(mem_addr);
          if (log_n < 16) log_a[log_n] = mem_addr;
          log_n++;
          wait_c = $urandom % 3;
        end
      end
    end
  end

  task automatic fetch(input logic [31:0] a, input bit nc, input string tag_req);
    int s, t, hw, n, lat, ref_l;
    bit cached, hit, eerr;
    logic [31:0] edata, base;
    int wi;
    s = (a / LB) % SETS;  t = (a / LB) / SETS;
    cached = cache_en && !nc;
    hit = 0; hw = 0; n = 0; eerr = 0; edata = 0;
    base = a & ~(LB - 1); wi = (a % LB) / 4;
    if (!cached) begin
      exp_a[0] = a & ~32'h3; n = 1;
      eerr = err_on && (err_addr == exp_a[0]);
      edata = eerr ? 0 : memf(exp_a[0]);
    end else begin
      for (int w = 0; w < WAYS; w++) if (mtag[s][w] == t) begin hit = 1; hw = w; end
      if (hit) begin
        edata = memf(a & ~32'h3);
        ref_l = mlru[s][hw];
        for (int w = 0; w < WAYS; w++) if (mlru[s][w] > ref_l) mlru[s][w]--;
        mlru[s][hw] = US - 1;
      end else begin
        int v = 0, vm = US - 1;
        for (int w = 0; w < WAYS; w++) if (mlru[s][w] < vm) begin v = w; vm = mlru[s][w]; end
        for (int k = 0; k < WORDS; k++) begin
          exp_a[k] = base + ((wi + k) % WORDS) * 4; n = k + 1;
          if (err_on && err_addr == exp_a[k]) begin eerr = 1; break; end
        end
        if (eerr) begin mtag[s][v] = -1; mlru[s][v] = 0; edata = 0; end
        else begin
          edata = memf(a & ~32'h3);
          mtag[s][v] = t;
          for (int w = 0; w < WAYS; w++) if (mlru[s][w] != 0) mlru[s][w]--;
          mlru[s][v] = US - 1;
        end
      end
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    log_n = 0;
    req_valid = 1; req_addr = a; req_nocache = nc; req_inv = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!rsp_valid && lat < 2000);
    chk(rsp_valid, {tag_req, " response arrives"}, 32'(rsp_valid), 1);
    chk(rsp_data == edata, {tag_req, " data"}, rsp_data, edata);
    chk(rsp_buserr == eerr, eerr ? "R8/R12 bus error flag" : {tag_req, " error flag"}, 32'(rsp_buserr), 32'(eerr));
    chk(log_n == n, hit ? "R3 memory reads on hit" : "R4 memory read count", log_n, n);
    for (int k = 0; k < n && k < log_n; k++)
      chk(log_a[k] == exp_a[k], "R4 read address order", log_a[k], exp_a[k]);
    if (hit) chk(lat == HD + 2, "R3 hit latency", lat, HD + 2);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R11 response pulse then idle", {rsp_valid, req_ready}, 32'b01);
  endtask

  task automatic inval(input logic [31:0] a);
    int s, t, hw;
    bit m;
    s = (a / LB) % SETS; t = (a / LB) / SETS; m = 0; hw = 0;
    if (cache_en) begin
      for (int w = 0; w < WAYS; w++) if (mtag[s][w] == t) begin m = 1; hw = w; end
      if (m) begin mtag[s][hw] = -1; mlru[s][hw] = 0; end
    end else
      for (int w = 0; w < WAYS; w++) begin mtag[s][w] = -1; mlru[s][w] = 0; end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_inv = 1; req_addr = a; req_nocache = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_inv = 0;
    chk(req_ready && !rsp_valid && !mem_req, "R11 invalidate takes one cycle", {req_ready, rsp_valid, mem_req}, 32'b100);
  endtask

  initial begin : main
    void'($urandom(32'd20240611));
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) begin mtag[s][w] = -1; mlru[s][w] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R1 reset state", {req_ready, rsp_valid, mem_req}, 32'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R1 idle after reset", {req_ready, rsp_valid, mem_req}, 32'b100);

    fetch(32'h0000_0106, 0, "R5");
    fetch(32'h0000_0104, 0, "R3");
    fetch(32'h0000_010C, 0, "R5 other word of refilled line");
    fetch(32'hFFFF_FFF8, 0, "R2 all-ones tag first fetch");
    fetch(32'hFFFF_FFF0, 0, "R2 all-ones tag second fetch");
    fetch(32'h0000_0208, 0, "R6");
    fetch(32'h0000_0308, 0, "R6");
    fetch(32'h0000_0408, 0, "R6");
    fetch(32'h0000_0104, 0, "R6 hit reorders");
    fetch(32'h0000_0500, 0, "R6 evict");
    fetch(32'h0000_0204, 0, "R6 evicted or kept");
    fetch(32'h0000_0104, 1, "R7 no-cache");
    fetch(32'h0000_0104, 0, "R7 state unchanged");
    cache_en = 0;
    fetch(32'h0000_0604, 0, "R7 disabled");
    cache_en = 1;
    fetch(32'h0000_0604, 0, "R7 bypassed line not cached");
    inval(32'h0000_0100);
    fetch(32'h0000_0104, 0, "R9 invalidated line refetched");
    inval(32'h0000_0700);
    fetch(32'h0000_0104, 0, "R9 invalidate miss keeps line");
    fetch(32'h0000_0010, 0, "R10 other set fill");
    cache_en = 0;
    inval(32'h0000_0100);
    cache_en = 1;
    fetch(32'h0000_0104, 0, "R10 set cleared");
    fetch(32'h0000_0014, 0, "R10 other set kept");
    err_on = 1; err_addr = 32'h0000_0828;
    fetch(32'h0000_0824, 0, "R8 refill error");
    err_on = 0;
    fetch(32'h0000_0824, 0, "R8 victim invalid afterwards");
    err_on = 1; err_addr = 32'h0000_0104;
    fetch(32'h0000_0104, 1, "R12 bypass error");
    err_on = 0;
    fetch(32'h0000_0104, 0, "R12 state unchanged");

    for (int i = 0; i < 500; i++) begin
      int op = $urandom % 100;
      logic [31:0] a = ((($urandom % 6) * SETS + ($urandom % SETS)) * LB) + ($urandom % LB);
      if (op < 6) cache_en = ~cache_en;
      else if (op < 16) inval(a);
      else begin
        if (op > 93) begin err_on = 1; err_addr = (a & ~(LB - 1)) + 4 * ($urandom % WORDS); end
        fetch(a, op > 84 && op < 94, "R6 random");
        err_on = 0;
      end
    end
    finish_run();
  end
endmodule